// File: doc/BRIEF.md
# Ethernet Frame Length Checker

This block watches an Ethernet frame as it streams past one byte per accepted cycle, counting every byte from the first byte of the destination address to the last byte of the frame check sequence. When the running count goes beyond a programmable ceiling, it raises a one-cycle abort and discards the rest of that frame. A separate enable lifts the ceiling so that frames of any size can pass.

As the frame goes by, the block also captures the two-byte type/length field. If length checking is enabled and the field holds a length rather than a protocol type, the block compares that length with the real payload size when the frame ends. A difference is not treated as an error that stops the frame. It is reported as one bit of a status word that the block presents for one cycle after the last byte. That word also carries the final byte count and a too-long flag. It is meant to feed the transmit or receive status vector of a MAC.

Top module: `frame_len_checker`

## Requirements
- R1: Each frame starts with a byte marked by `inSof` and ends with a byte marked by `inEof`, both qualified by `inValid`. The count covers every accepted byte of the frame, and a start marker always restarts it at 1. One cycle after the end byte is accepted, `statValid` is high for exactly one cycle and `statLen` holds the count.
- R2: With `hugeEn` low, the byte that brings the count to `maxLen`+1 makes `abort` high for exactly one cycle, in the cycle after that byte is accepted. A frame of exactly `maxLen` bytes is never aborted.
- R3: After an abort, the remaining bytes of the frame are ignored. At that frame's end byte, the status word shows `statTooLong`=1, `statLen`=`maxLen`+1 and `statLenMismatch`=0. This also holds when the aborting byte is itself the end byte.
- R4: With `hugeEn` high, no frame is ever aborted and `statTooLong` stays 0. The count saturates at 65535.
- R5: The type/length field is big-endian in frame bytes 12 (high) and 13 (low), counted from 0. With `lenCheckEn` high, a field value of 1500 or less is a length and is compared with the payload size, which is the byte count minus 18. A difference sets `statLenMismatch`.
- R6: A field value above 1500 is a protocol type and never causes a mismatch.
- R7: With `lenCheckEn` low, `statLenMismatch` is always 0.
- R8: A 64-byte frame (46-byte padded payload) whose stated length is below 46 is not a mismatch.
- R9: A frame that ends before byte 13 is never compared. A frame of 14 to 17 bytes whose field holds a length always mismatches.
- R10: Bytes with `inValid` low are ignored, and so are their markers. Valid bytes that arrive outside a frame are ignored too: they produce no abort and no status. After reset, `abort` and `statValid` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | A byte is present this cycle |
| inData | input | 8 | Frame byte |
| inSof | input | 1 | This byte is the first of a frame |
| inEof | input | 1 | This byte is the last of a frame |
| maxLen | input | 16 | Largest permitted frame size in bytes |
| hugeEn | input | 1 | Lift the size ceiling |
| lenCheckEn | input | 1 | Compare the type/length field with the payload size |
| abort | output | 1 | One-cycle pulse when the frame passes the ceiling |
| statValid | output | 1 | Status word valid (one cycle after the end byte) |
| statLen | output | 16 | Counted frame length |
| statTooLong | output | 1 | Frame was aborted for size |
| statLenMismatch | output | 1 | Stated length differs from the payload size |

## Verification
The properties assume that `maxLen` is nonzero, and that `maxLen` and `hugeEn` stay constant from the first byte of a frame until its status word appears. The length bound on the status word and the too-long length value both depend on that. The stimulus changes the ceiling, the size override and the check enable only between frames, and always sets a ceiling of at least 20 bytes. Random frames mix lengths around the ceiling, the header, the padded minimum and the 1500 boundary, and idle cycles inside frames carry random markers to exercise the qualifier.

// File: rtl/flc_pkg.sv
package flc_pkg;

  // Strobes from control to datapath for one accepted byte
  typedef struct packed {
    logic inc;    // byte belongs to the frame being counted
    logic clear;  // byte is the first of a new frame
  } flcStrobe_t;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_RUN  = 2'd1,
    S_DROP = 2'd2
  } flcState_t;

  localparam int FIELD_W = 16;

endpackage

// File: rtl/flc_datapath.sv
module flc_datapath
  import flc_pkg::*;
#(
  parameter int LEN_W         = 16,
  parameter int FIELD_POS     = 12,
  parameter int HDR_BYTES     = 14,
  parameter int FCS_BYTES     = 4,
  parameter int MAX_LEN_VALUE = 1500,
  parameter int MIN_PAYLOAD   = 46
) (
  input  logic             clk,
  input  logic             rstN,
  input  flcStrobe_t       strobe,
  input  logic [7:0]       inData,
  input  logic [LEN_W-1:0] maxLen,
  input  logic             lenCheckEn,
  output logic [LEN_W-1:0] cnt,
  output logic [LEN_W-1:0] nextCnt,
  output logic             overMax,
  output logic             mismatch
);

  // Count value reached when the high and low field bytes arrive
  localparam logic [LEN_W-1:0] HI_AT    = LEN_W'(FIELD_POS + 1);
  localparam logic [LEN_W-1:0] LO_AT    = LEN_W'(FIELD_POS + 2);
  localparam logic [LEN_W-1:0] OVERHEAD = LEN_W'(HDR_BYTES + FCS_BYTES);
  localparam logic [LEN_W-1:0] PAD_LEN  = LEN_W'(HDR_BYTES + FCS_BYTES + MIN_PAYLOAD);
  localparam logic [LEN_W-1:0] CNT_TOP  = '1;
  localparam logic [FIELD_W-1:0] LEN_LIMIT = FIELD_W'(MAX_LEN_VALUE);
  localparam logic [FIELD_W-1:0] PAD_MIN   = FIELD_W'(MIN_PAYLOAD);

  logic [FIELD_W-1:0] fieldQ;
  logic [FIELD_W-1:0] fieldNow;
  logic               fieldWhole;
  logic               isLength;
  logic               payloadOk;
  logic               padOk;

  // Next count: restart at 1 on a start byte, otherwise saturate
  always_comb begin
    if (strobe.clear) begin
      nextCnt = LEN_W'(1);
    end else if (cnt == CNT_TOP) begin
      nextCnt = cnt;
    end else begin
      nextCnt = cnt + LEN_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (strobe.inc) begin
      cnt <= nextCnt;
    end
  end

  // Type/length capture, most significant byte first
  always_ff @(posedge clk) begin
    if (!rstN) begin
      fieldQ <= '0;
    end else if (strobe.inc) begin
      if (nextCnt == HI_AT) begin
        fieldQ[15:8] <= inData;
      end
      if (nextCnt == LO_AT) begin
        fieldQ[7:0] <= inData;
      end
    end
  end

  // Field as it stands including the byte on the input this cycle
  always_comb begin
    fieldNow = fieldQ;
    if (strobe.inc && nextCnt == LO_AT) begin
      fieldNow[7:0] = inData;
    end
  end

  assign overMax = nextCnt > maxLen;

  always_comb begin
    fieldWhole = nextCnt >= LO_AT;
    isLength   = fieldNow <= LEN_LIMIT;
    payloadOk  = (nextCnt >= OVERHEAD) &&
                 ((nextCnt - OVERHEAD) == LEN_W'(fieldNow));
    padOk      = (nextCnt == PAD_LEN) && (fieldNow < PAD_MIN);
    mismatch   = lenCheckEn && fieldWhole && isLength && !payloadOk && !padOk;
  end

endmodule

// File: rtl/flc_control.sv
module flc_control
  import flc_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic             inSof,
  input  logic             inEof,
  input  logic             hugeEn,
  input  logic [LEN_W-1:0] cnt,
  input  logic [LEN_W-1:0] nextCnt,
  input  logic             overMax,
  input  logic             mismatch,
  output flcStrobe_t       strobe,
  output logic             abort,
  output logic             statValid,
  output logic [LEN_W-1:0] statLen,
  output logic             statTooLong,
  output logic             statLenMismatch
);

  flcState_t state;
  logic      tooLong;
  logic      dropEnd;

  always_comb begin
    strobe.clear = inValid && inSof;
    strobe.inc   = inValid && (inSof || state == S_RUN);
    tooLong      = overMax && !hugeEn;
    dropEnd      = inValid && !inSof && inEof && state == S_DROP;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state           <= S_IDLE;
      abort           <= 1'b0;
      statValid       <= 1'b0;
      statLen         <= '0;
      statTooLong     <= 1'b0;
      statLenMismatch <= 1'b0;
    end else begin
      abort     <= 1'b0;
      statValid <= 1'b0;
      if (strobe.inc) begin
        if (tooLong) begin
          abort <= 1'b1;
        end
        if (inEof) begin
          statValid       <= 1'b1;
          statLen         <= nextCnt;
          statTooLong     <= tooLong;
          statLenMismatch <= !tooLong && mismatch;
          state           <= S_IDLE;
        end else begin
          state <= tooLong ? S_DROP : S_RUN;
        end
      end else if (dropEnd) begin
        statValid       <= 1'b1;
        statLen         <= cnt;
        statTooLong     <= 1'b1;
        statLenMismatch <= 1'b0;
        state           <= S_IDLE;
      end
    end
  end

endmodule

// File: rtl/frame_len_checker.sv
module frame_len_checker
  import flc_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [7:0]       inData,
  input  logic             inSof,
  input  logic             inEof,
  input  logic [LEN_W-1:0] maxLen,
  input  logic             hugeEn,
  input  logic             lenCheckEn,
  output logic             abort,
  output logic             statValid,
  output logic [LEN_W-1:0] statLen,
  output logic             statTooLong,
  output logic             statLenMismatch
);

  flcStrobe_t       strobe;
  logic [LEN_W-1:0] cnt;
  logic [LEN_W-1:0] nextCnt;
  logic             overMax;
  logic             mismatch;

  flc_datapath #(.LEN_W(LEN_W)) i_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .inData     (inData),
    .maxLen     (maxLen),
    .lenCheckEn (lenCheckEn),
    .cnt        (cnt),
    .nextCnt    (nextCnt),
    .overMax    (overMax),
    .mismatch   (mismatch)
  );

  flc_control #(.LEN_W(LEN_W)) i_control (
    .clk             (clk),
    .rstN            (rstN),
    .inValid         (inValid),
    .inSof           (inSof),
    .inEof           (inEof),
    .hugeEn          (hugeEn),
    .cnt             (cnt),
    .nextCnt         (nextCnt),
    .overMax         (overMax),
    .mismatch        (mismatch),
    .strobe          (strobe),
    .abort           (abort),
    .statValid       (statValid),
    .statLen         (statLen),
    .statTooLong     (statTooLong),
    .statLenMismatch (statLenMismatch)
  );

endmodule

// File: rtl/flc_checker.sv
module flc_checker #(
  parameter int LEN_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic [LEN_W-1:0] maxLen,
  input logic             hugeEn,
  input logic             lenCheckEn,
  input logic             abort,
  input logic             statValid,
  input logic [LEN_W-1:0] statLen,
  input logic             statTooLong,
  input logic             statLenMismatch
);

  // abort lasts one cycle when the ceiling is nonzero
  p_abort_pulse_r2: assert property (@(posedge clk) disable iff (!rstN)
    abort && maxLen != '0 |=> !abort);

  // lifted ceiling never aborts
  p_huge_no_abort_r4: assert property (@(posedge clk) disable iff (!rstN)
    hugeEn |=> !abort);

  // check disabled means no mismatch reported
  p_no_check_r7: assert property (@(posedge clk) disable iff (!rstN)
    !lenCheckEn |=> !(statValid && statLenMismatch));

  // aborted frames carry no mismatch
  p_abort_excl_r3: assert property (@(posedge clk) disable iff (!rstN)
    statValid |-> !(statTooLong && statLenMismatch));

  // aborted frame length is one beyond the ceiling
  p_toolong_len_r3: assert property (@(posedge clk) disable iff (!rstN)
    statValid && statTooLong && $stable(maxLen) |-> statLen == maxLen + LEN_W'(1));

  // a passing frame fits under a ceiling that was in force
  p_len_bound_r2: assert property (@(posedge clk) disable iff (!rstN)
    statValid && !statTooLong && !$past(hugeEn) && $stable(maxLen) |-> statLen <= maxLen);

endmodule

bind frame_len_checker flc_checker #(.LEN_W(LEN_W)) i_flc_checker (
  .clk             (clk),
  .rstN            (rstN),
  .maxLen          (maxLen),
  .hugeEn          (hugeEn),
  .lenCheckEn      (lenCheckEn),
  .abort           (abort),
  .statValid       (statValid),
  .statLen         (statLen),
  .statTooLong     (statTooLong),
  .statLenMismatch (statLenMismatch)
);

// File: tb/test_frame_len_checker.sv
`timescale 1ns/1ps
module test_frame_len_checker;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [7:0]  inData = '0;
  logic        inSof = 1'b0;
  logic        inEof = 1'b0;
  logic [15:0] maxLen = 16'd1518;
  logic        hugeEn = 1'b0;
  logic        lenCheckEn = 1'b0;
  logic        abort;
  logic        statValid;
  logic [15:0] statLen;
  logic        statTooLong;
  logic        statLenMismatch;

  int checkCnt = 0;
  int failCnt  = 0;
  int abortSeen = 0;
  int statSeen  = 0;
  int gotLen = 0;
  int gotLong = 0;
  int gotMis = 0;

  always #10 clk = ~clk;

  frame_len_checker i_frame_len_checker (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData),
    .inSof(inSof), .inEof(inEof), .maxLen(maxLen), .hugeEn(hugeEn),
    .lenCheckEn(lenCheckEn), .abort(abort), .statValid(statValid),
    .statLen(statLen), .statTooLong(statTooLong), .statLenMismatch(statLenMismatch)
  );

  // Output monitor, sampled mid-cycle
  always @(negedge clk) begin
    if (rstN) begin
      if (abort) abortSeen++;
      if (statValid) begin
        statSeen++;
        gotLen  = int'(statLen);
        gotLong = int'(statTooLong);
        gotMis  = int'(statLenMismatch);
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int expAbort(int len, int mx, bit huge);
    return (!huge && len > mx) ? 1 : 0;
  endfunction

  function automatic int expLen(int len, int mx, bit huge);
    if (huge) return (len > 65535) ? 65535 : len;
    return (len > mx) ? mx + 1 : len;
  endfunction

  function automatic int expMis(int len, int fld, int mx, bit huge, bit chk);
    if (expAbort(len, mx, huge) != 0) return 0;
    if (!chk || len < 14 || fld > 1500) return 0;
    if (len >= 18 && len - 18 == fld) return 0;
    if (len == 64 && fld < 46) return 0;
    return 1;
  endfunction

  task automatic clearMon();
    abortSeen = 0;
    statSeen  = 0;
  endtask

  // Drive one frame; idlePct gives the chance of an idle cycle before a byte
  task automatic sendFrame(input int len, input int fld, input int idlePct);
    for (int i = 0; i < len; i++) begin
      while (idlePct > 0 && ($urandom % 100) < idlePct) begin
        @(posedge clk); #2;
        inValid = 1'b0;
        inSof   = 1'($urandom);
        inEof   = 1'($urandom);
        inData  = 8'($urandom);
      end
      @(posedge clk); #2;
      inValid = 1'b1;
      inSof   = (i == 0);
      inEof   = (i == len - 1);
      if (i == 12)      inData = 8'(fld >> 8);
      else if (i == 13) inData = 8'(fld);
      else              inData = 8'($urandom);
    end
    @(posedge clk); #2;
    inValid = 1'b0; inSof = 1'b0; inEof = 1'b0;
    repeat (2) @(posedge clk);
    #1;
  endtask

  task automatic runFrame(input int len, input int fld, input int idlePct, input string misTag);
    int ea, el, em;
    ea = expAbort(len, int'(maxLen), hugeEn);
    el = expLen(len, int'(maxLen), hugeEn);
    em = expMis(len, fld, int'(maxLen), hugeEn, lenCheckEn);
    clearMon();
    sendFrame(len, fld, idlePct);
    check(abortSeen == ea, hugeEn ? "R4 abort count" : "R2 abort count", abortSeen, ea);
    check(statSeen == 1, "R1 status count", statSeen, 1);
    check(gotLen == el, (ea != 0) ? "R3 length" : "R1 length", gotLen, el);
    check(gotLong == ea, (ea != 0) ? "R3 too-long flag" : "R2 too-long flag", gotLong, ea);
    check(gotMis == em, misTag, gotMis, em);
  endtask

  task automatic setCfg(input int mx, input bit huge, input bit chk);
    @(posedge clk); #2;
    maxLen = 16'(mx); hugeEn = huge; lenCheckEn = chk;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #2 rstN = 1'b1;
    @(negedge clk);
    check(abort == 1'b0, "R10 reset abort", int'(abort), 0);
    check(statValid == 1'b0, "R10 reset status", int'(statValid), 0);

    // Ceiling edges
    setCfg(100, 0, 1);
    runFrame(100, 82, 0, "R5 exact match");
    runFrame(101, 83, 0, "R3 one over");
    runFrame(150, 0, 20, "R3 drop tail");
    setCfg(1518, 0, 1);
    runFrame(1518, 1500, 0, "R5 max length field");
    runFrame(1518, 1501, 0, "R6 type above boundary");
    runFrame(80, 50, 0, "R5 mismatch");
    runFrame(80, 16'h0800, 0, "R6 type value");
    runFrame(64, 10, 0, "R8 padded short length");
    runFrame(64, 46, 0, "R8 padded exact");
    runFrame(64, 50, 0, "R8 padded larger mismatch");
    runFrame(10, 0, 0, "R9 too short to compare");
    runFrame(13, 0, 0, "R9 field incomplete");
    runFrame(14, 0, 0, "R9 header only");
    runFrame(16, 3, 30, "R9 short with length");
    setCfg(1518, 0, 0);
    runFrame(80, 50, 0, "R7 check disabled");
    setCfg(1518, 1, 1);
    runFrame(2000, 1982, 0, "R4 huge frame");

    // Bytes outside any frame are ignored
    setCfg(20, 0, 1);
    clearMon();
    for (int i = 0; i < 50; i++) begin
      @(posedge clk); #2;
      inValid = 1'b1; inSof = 1'b0; inEof = (i == 49); inData = 8'($urandom);
    end
    @(posedge clk); #2;
    inValid = 1'b0; inEof = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check(abortSeen == 0, "R10 stray bytes abort", abortSeen, 0);
    check(statSeen == 0, "R10 stray bytes status", statSeen, 0);

    // Constrained random frames
    for (int n = 0; n < 60; n++) begin
      int len, fld, mx, sel;
      sel = $urandom % 5;
      case (sel)
        0: len = 1 + ($urandom % 17);
        1: len = 60 + ($urandom % 10);
        2: len = 18 + ($urandom % 1600);
        default: len = 18 + ($urandom % 300);
      endcase
      sel = $urandom % 5;
      case (sel)
        0: fld = (len >= 18) ? len - 18 : 0;
        1: fld = $urandom % 1501;
        2: fld = 1501 + ($urandom % 64000);
        3: fld = $urandom % 46;
        default: fld = 1499 + ($urandom % 4);
      endcase
      mx = 20 + ($urandom % 1600);
      setCfg(mx, ($urandom % 4) == 0, ($urandom % 4) != 0);
      runFrame(len, fld, 10, "R5 random mismatch");
    end

    // Saturation of the counter
    setCfg(1518, 1, 0);
    runFrame(65540, 0, 0, "R4 saturated frame");

    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checkCnt++;
    failCnt++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

endmodule